// File: doc/BRIEF.md
# DRAM Self-Refresh Entry and Exit Sequencer

This block sits on the controller side of a DDR2-class SDRAM interface. It puts the memory into its self-refreshing low-power state and brings it back out. A power manager raises a one-cycle request to sleep or to wake. The block then drives the clock-enable pin, the four command strobes, the on-die-termination pin and an enable for the external memory clock. All timing limits are parameters counted in controller clock cycles.

A sleep request waits until every bank is idle and until a refresh has been seen since the last wake-up. The block then pulls termination low for a lead time, issues the entry command, and lets the memory clock stop after one more cycle. It holds clock-enable low for a minimum residency. On wake it restarts the memory clock and waits for it to settle before raising clock-enable. It then drives no-operation commands until the memory is usable again. Two outputs tell the main scheduler when reads, and when all other commands, may be issued again.

Top module: `dram_lp_sequencer`

## Requirements
- R1: While reset is high and in the first cycle after it, CKE is low, CS#, RAS#, CAS# and WE# are all high (deselect), ODT is low, the memory clock enable is high, and both rd_ok and cmd_ok are low.
- R2: The entry command is the only cycle in which CKE falls. In that cycle CS#, RAS# and CAS# are low and WE# is high ({cs_n,ras_n,cas_n,we_n} = 4'b0001). While asleep, CS# is high.
- R3: CKE falls only if banks_idle was high in the previous cycle. A sleep request made while banks are busy is kept and carried out once banks_idle rises.
- R4: Before the entry cycle, ODT is low for T_AOFD consecutive cycles, counted while odt_req is high.
- R5: CKE stays low for at least T_CKE cycles. A wake request made in the entry cycle is held back, so CKE rises after exactly 1 + T_CKE + T_CLK_STAB low cycles.
- R6: The memory clock enable stays high in the first cycle after the entry cycle and is low for the rest of the residency. It is high for exactly T_CLK_STAB cycles before CKE rises.
- R7: From the cycle in which CKE rises until both gates open, CKE stays high and the command pins carry a no-operation (CS# low, RAS#, CAS# and WE# high).
- R8: The first cycle with CKE high is counted as cycle 0. rd_ok first rises in cycle T_XSRD and cmd_ok first rises in cycle T_XSNR.
- R9: ODT is never high while rd_ok is low.
- R10: After each wake-up, a sleep request is held until ref_seen has pulsed. When the request and ref_seen arrive in the same cycle, the termination lead-in starts two cycles later.
- R11: In normal operation, ODT follows odt_req one cycle later.
- R12: A wake request made outside the sleep phase has no effect. It neither keeps CKE high nor shortens a later residency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| enter_req | input | 1 | One-cycle request to enter self-refresh |
| wake_req | input | 1 | One-cycle request to leave self-refresh |
| banks_idle | input | 1 | High when every bank is precharged |
| ref_seen | input | 1 | Pulses when the scheduler issues an auto-refresh |
| odt_req | input | 1 | Termination level the scheduler wants |
| dram_cke | output | 1 | Memory clock-enable pin |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_odt | output | 1 | On-die termination pin |
| dram_clk_en | output | 1 | Enable for the external memory clock |
| rd_ok | output | 1 | Scheduler may issue reads |
| cmd_ok | output | 1 | Scheduler may issue non-read commands |

## Verification
A sleep request and the refresh that clears the re-entry debt can land in the same cycle. Both then update their own registers at one edge. The bench pulses enter_req and ref_seen together right after a wake-up. It expects cmd_ok to stay high for one more cycle and to drop in the next, then expects a complete termination lead-in and an entry command. A design that drops the request or lets it overtake the refresh shows up as a missing or early cmd_ok drop.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE,
    ST_ODT_DRAIN,
    ST_SRE_CMD,
    ST_ASLEEP,
    ST_CLK_WARM,
    ST_EXIT_NOP
  } lp_state_e;

  typedef struct packed {
    logic cke;
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic odt;
    logic clk_en;
    logic rd_ok;
    logic cmd_ok;
  } lp_pins_t;

  localparam lp_pins_t PINS_AT_RESET = '{
    cke: 1'b0, cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1,
    odt: 1'b0, clk_en: 1'b1, rd_ok: 1'b0, cmd_ok: 1'b0
  };

endpackage

// File: rtl/lp_timer.sv
module lp_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_n
);

  always_comb begin
    if (restart)      cnt_n = '0;
    else if (&cnt_q)  cnt_n = cnt_q;
    else              cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_n;
  end

endmodule

// File: rtl/lp_owed_flag.sv
module lp_owed_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic owed
);

  always_ff @(posedge clk) begin
    if (rst)      owed <= 1'b0;
    else if (set) owed <= 1'b1;
    else if (clr) owed <= 1'b0;
  end

  // R10: once set, the debt survives until a refresh is observed
  p_owed_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (owed && !clr) |=> owed);
  p_owed_set_r10: assert property (@(posedge clk) disable iff (rst)
    set |=> owed);

endmodule

// File: rtl/lp_pin_decode.sv
module lp_pin_decode
  import lp_seq_pkg::*;
#(
  parameter int W      = 4,
  parameter int T_XSRD = 1,
  parameter int T_XSNR = 1
) (
  input  lp_state_e    state,
  input  logic [W-1:0] cnt,
  input  logic         odt_req,
  output lp_pins_t     pins
);

  localparam logic [W-1:0] RD_AT  = W'(T_XSRD);
  localparam logic [W-1:0] CMD_AT = W'(T_XSNR);

  always_comb begin
    pins        = PINS_AT_RESET;
    pins.cke    = 1'b1;
    case (state)
      ST_ACTIVE: begin
        pins.odt    = odt_req;
        pins.rd_ok  = 1'b1;
        pins.cmd_ok = 1'b1;
      end
      ST_ODT_DRAIN: ;
      ST_SRE_CMD: begin
        pins.cke   = 1'b0;
        pins.cs_n  = 1'b0;
        pins.ras_n = 1'b0;
        pins.cas_n = 1'b0;
      end
      ST_ASLEEP: begin
        pins.cke    = 1'b0;
        pins.clk_en = (cnt == '0);
      end
      ST_CLK_WARM: pins.cke = 1'b0;
      ST_EXIT_NOP: begin
        pins.cs_n   = 1'b0;
        pins.rd_ok  = (cnt >= RD_AT);
        pins.cmd_ok = (cnt >= CMD_AT);
        pins.odt    = (cnt >= RD_AT) && odt_req;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dram_lp_sequencer.sv
module dram_lp_sequencer
  import lp_seq_pkg::*;
#(
  parameter int T_AOFD     = 3,
  parameter int T_CKE      = 4,
  parameter int T_CLK_STAB = 5,
  parameter int T_XSNR     = 6,
  parameter int T_XSRD     = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic enter_req,
  input  logic wake_req,
  input  logic banks_idle,
  input  logic ref_seen,
  input  logic odt_req,
  output logic dram_cke,
  output logic dram_cs_n,
  output logic dram_ras_n,
  output logic dram_cas_n,
  output logic dram_we_n,
  output logic dram_odt,
  output logic dram_clk_en,
  output logic rd_ok,
  output logic cmd_ok
);

  localparam int T_XMAX = (T_XSRD > T_XSNR) ? T_XSRD : T_XSNR;
  localparam int CW     = $clog2(T_AOFD + T_CKE + T_CLK_STAB + T_XMAX + 2);
  localparam logic [CW-1:0] LIM_AOFD = CW'(T_AOFD - 1);
  localparam logic [CW-1:0] LIM_CKE  = CW'(T_CKE - 1);
  localparam logic [CW-1:0] LIM_WARM = CW'(T_CLK_STAB - 1);
  localparam logic [CW-1:0] LIM_EXIT = CW'(T_XMAX - 1);

  lp_state_e     state_q, state_d;
  logic [CW-1:0] tmr_q, tmr_n;
  logic          enter_pend_q, wake_pend_q, owed;
  lp_pins_t      pins_nxt, pins_q;

  lp_timer #(.W(CW)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .restart (state_d != state_q),
    .cnt_q   (tmr_q),
    .cnt_n   (tmr_n)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_ACTIVE:
        if (enter_pend_q && banks_idle && !owed) state_d = ST_ODT_DRAIN;
      ST_ODT_DRAIN:
        if (tmr_q >= LIM_AOFD) state_d = banks_idle ? ST_SRE_CMD : ST_ACTIVE;
      ST_SRE_CMD:
        state_d = ST_ASLEEP;
      ST_ASLEEP:
        if (wake_pend_q && tmr_q >= LIM_CKE) state_d = ST_CLK_WARM;
      ST_CLK_WARM:
        if (tmr_q >= LIM_WARM) state_d = ST_EXIT_NOP;
      ST_EXIT_NOP:
        if (tmr_q >= LIM_EXIT) state_d = ST_ACTIVE;
      default:
        state_d = ST_CLK_WARM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_CLK_WARM;
    else     state_q <= state_d;
  end

  // sleep request: kept until the entry command goes out
  always_ff @(posedge clk) begin
    if (rst)
      enter_pend_q <= 1'b0;
    else if (state_q == ST_SRE_CMD)
      enter_pend_q <= 1'b0;
    else if (enter_req && state_q != ST_ODT_DRAIN && state_q != ST_ASLEEP)
      enter_pend_q <= 1'b1;
  end

  // wake request: only heard around the sleep phase, held until residency ends
  always_ff @(posedge clk) begin
    if (rst)
      wake_pend_q <= 1'b0;
    else if (state_q == ST_ASLEEP && state_d != ST_ASLEEP)
      wake_pend_q <= 1'b0;
    else if (wake_req && (state_q == ST_ODT_DRAIN || state_q == ST_SRE_CMD ||
                          state_q == ST_ASLEEP))
      wake_pend_q <= 1'b1;
  end

  lp_owed_flag u_owed (
    .clk  (clk),
    .rst  (rst),
    .set  (state_q == ST_CLK_WARM && state_d == ST_EXIT_NOP),
    .clr  (ref_seen),
    .owed (owed)
  );

  lp_pin_decode #(.W(CW), .T_XSRD(T_XSRD), .T_XSNR(T_XSNR)) u_dec (
    .state   (state_d),
    .cnt     (tmr_n),
    .odt_req (odt_req),
    .pins    (pins_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) pins_q <= PINS_AT_RESET;
    else     pins_q <= pins_nxt;
  end

  assign dram_cke    = pins_q.cke;
  assign dram_cs_n   = pins_q.cs_n;
  assign dram_ras_n  = pins_q.ras_n;
  assign dram_cas_n  = pins_q.cas_n;
  assign dram_we_n   = pins_q.we_n;
  assign dram_odt    = pins_q.odt;
  assign dram_clk_en = pins_q.clk_en;
  assign rd_ok       = pins_q.rd_ok;
  assign cmd_ok      = pins_q.cmd_ok;

  // ---------------- pin-level watch counters for the properties ----------------
  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  logic [CW-1:0] odt_low_run, cke_low_run, clk_run, exit_age;
  logic          cke_prev, ref_debt;

  always_ff @(posedge clk) begin
    if (rst) begin
      odt_low_run <= '0;
      cke_low_run <= '1;
      clk_run     <= '1;
      exit_age    <= '0;
      cke_prev    <= 1'b0;
      ref_debt    <= 1'b0;
    end else begin
      odt_low_run <= dram_odt    ? '0 : sat_inc(odt_low_run);
      cke_low_run <= dram_cke    ? '0 : sat_inc(cke_low_run);
      clk_run     <= dram_clk_en ? sat_inc(clk_run) : '0;
      exit_age    <= dram_cke    ? sat_inc(exit_age) : '0;
      cke_prev    <= dram_cke;
      if (dram_cke && !cke_prev) ref_debt <= 1'b1;
      else if (ref_seen)         ref_debt <= 1'b0;
    end
  end

  p_sre_code_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_cke) |-> (!dram_cs_n && !dram_ras_n && !dram_cas_n && dram_we_n));
  p_banks_idle_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_cke) |-> $past(banks_idle));
  p_odt_lead_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_cke) |-> (odt_low_run >= CW'(T_AOFD)));
  p_cke_min_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_cke) |-> (cke_low_run >= CW'(T_CKE)));
  p_clk_hold_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_cke) |=> dram_clk_en);
  p_clk_warm_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_cke) |-> (clk_run >= CW'(T_CLK_STAB)));
  p_exit_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (dram_cke && !cmd_ok) |-> (dram_ras_n && dram_cas_n && dram_we_n));
  p_rd_gate_r8: assert property (@(posedge clk) disable iff (rst)
    rd_ok |-> (exit_age >= CW'(T_XSRD)));
  p_cmd_gate_r8: assert property (@(posedge clk) disable iff (rst)
    cmd_ok |-> (exit_age >= CW'(T_XSNR)));
  p_odt_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_ok |-> !dram_odt);
  p_ref_first_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_cke) |-> !ref_debt);

endmodule

// File: tb/dram_lp_sequencer_bench.sv
`timescale 1ns/1ps
module dram_lp_sequencer_bench;

  localparam int A  = 3;
  localparam int K  = 4;
  localparam int S  = 5;
  localparam int XN = 6;
  localparam int XR = 10;

  logic clk = 1'b0;
  logic rst, enter_req, wake_req, banks_idle, ref_seen, odt_req;
  logic dram_cke, dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n;
  logic dram_odt, dram_clk_en, rd_ok, cmd_ok;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dram_lp_sequencer #(
    .T_AOFD(A), .T_CKE(K), .T_CLK_STAB(S), .T_XSNR(XN), .T_XSRD(XR)
  ) u_dram_lp_sequencer (
    .clk(clk), .rst(rst), .enter_req(enter_req), .wake_req(wake_req),
    .banks_idle(banks_idle), .ref_seen(ref_seen), .odt_req(odt_req),
    .dram_cke(dram_cke), .dram_cs_n(dram_cs_n), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_odt(dram_odt),
    .dram_clk_en(dram_clk_en), .rd_ok(rd_ok), .cmd_ok(cmd_ok)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  function automatic int cmd_code();
    return {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n};
  endfunction

  // current sample is cycle 0 of the exit (first CKE-high cycle)
  task automatic check_exit(input string tag);
    int rd_at = -1, cmd_at = -1, odt_bad = 0, nop_bad = 0, cke_bad = 0;
    for (int i = 0; i < 64; i++) begin
      if (!dram_cke) cke_bad++;
      if (!rd_ok && dram_odt) odt_bad++;
      if (!cmd_ok && cmd_code() != 4'b0111) nop_bad++;
      if (rd_ok && rd_at < 0) rd_at = i;
      if (cmd_ok && cmd_at < 0) cmd_at = i;
      if (rd_ok && cmd_ok) break;
      cyc();
    end
    chk("R7", {tag, " CKE held high"}, cke_bad, 0);
    chk("R7", {tag, " NOP while gated"}, nop_bad, 0);
    chk("R8", {tag, " read gate cycle"}, rd_at, XR);
    chk("R8", {tag, " command gate cycle"}, cmd_at, XN);
    chk("R9", {tag, " ODT while reads gated"}, odt_bad, 0);
  endtask

  // waits for the entry command, starting with run0 ODT-low cycles already seen
  task automatic do_entry(input int run0);
    int run = run0;
    int seen = 0;
    for (int k = 0; k < 64; k++) begin
      cyc();
      enter_req = 1'b0;
      ref_seen  = 1'b0;
      if (!dram_cke) begin seen = 1; break; end
      run = dram_odt ? 0 : run + 1;
    end
    chk("R2", "entry command seen", seen, 1);
    chk("R2", "entry command code", cmd_code(), 4'b0001);
    chk("R4", "ODT low lead cycles", run, A);
  endtask

  // current sample is the entry cycle; returns the number of CKE-low cycles
  task automatic sleep_and_wake(input int delay, output int low);
    int run = 0;
    low = 1;
    if (delay == 0) wake_req = 1'b1;
    for (int k = 0; k < 400; k++) begin
      cyc();
      wake_req = 1'b0;
      if (dram_cke) break;
      low++;
      if (k == 0) chk("R6", "clock kept after entry", dram_clk_en, 1);
      if (k == 1) begin
        chk("R6", "clock stopped in sleep", dram_clk_en, 0);
        chk("R2", "deselect in sleep", dram_cs_n, 1);
      end
      run = dram_clk_en ? run + 1 : 0;
      if (delay > 0 && k == delay - 1) wake_req = 1'b1;
    end
    chk("R6", "clock warm-up cycles", run, S);
    if (delay == 0) chk("R5", "early wake deferred", low, 1 + K + S);
    else            chk("R5", "CKE minimum low", int'(low >= 1 + K), 1);
  endtask

  task automatic t_reset();
    rst = 1'b1; enter_req = 1'b0; wake_req = 1'b0; banks_idle = 1'b1;
    ref_seen = 1'b0; odt_req = 1'b1;
    repeat (3) cyc();
    chk("R1", "reset CKE", dram_cke, 0);
    chk("R1", "reset command", cmd_code(), 4'b1111);
    chk("R1", "reset ODT", dram_odt, 0);
    chk("R1", "reset clock enable", dram_clk_en, 1);
    chk("R1", "reset gates", {rd_ok, cmd_ok}, 0);
    rst = 1'b0;
    cyc();
    chk("R1", "first cycle CKE", dram_cke, 0);
    chk("R1", "first cycle gates", {rd_ok, cmd_ok}, 0);
  endtask

  task automatic t_powerup();
    for (int k = 0; k < 64; k++) begin
      if (dram_cke) break;
      cyc();
    end
    check_exit("power-up");
  endtask

  task automatic t_refresh_gate();
    int low;
    int bad = 0;
    enter_req = 1'b1;
    for (int k = 0; k < 12; k++) begin
      cyc();
      enter_req = 1'b0;
      if (!dram_cke || !cmd_ok) bad++;
    end
    chk("R10", "no entry while refresh owed", bad, 0);
    ref_seen = 1'b1;
    do_entry(0);
    sleep_and_wake(0, low);
    check_exit("after early wake");
  endtask

  task automatic t_same_cycle();
    int low;
    enter_req = 1'b1;
    ref_seen  = 1'b1;
    cyc();
    enter_req = 1'b0;
    ref_seen  = 1'b0;
    chk("R10", "still active one cycle later", cmd_ok, 1);
    cyc();
    chk("R10", "lead-in two cycles later", cmd_ok, 0);
    do_entry(1);
    sleep_and_wake(20, low);
    chk("R5", "late wake residency", int'(low >= 21), 1);
    check_exit("after late wake");
  endtask

  task automatic t_bank_busy();
    int low;
    int bad = 0;
    ref_seen = 1'b1;
    cyc();
    ref_seen   = 1'b0;
    banks_idle = 1'b0;
    enter_req  = 1'b1;
    for (int k = 0; k < 10; k++) begin
      cyc();
      enter_req = 1'b0;
      if (!dram_cke || !cmd_ok) bad++;
    end
    chk("R3", "no entry while banks busy", bad, 0);
    banks_idle = 1'b1;
    cyc();
    chk("R3", "held request starts lead-in", cmd_ok, 0);
    do_entry(1);
    sleep_and_wake(0, low);
    check_exit("after bank wait");
  endtask

  task automatic t_odt_and_stray_wake();
    int low;
    int bad = 0;
    odt_req = 1'b0;
    cyc();
    chk("R11", "ODT follows low", dram_odt, 0);
    odt_req = 1'b1;
    cyc();
    chk("R11", "ODT follows high", dram_odt, 1);
    wake_req = 1'b1;
    for (int k = 0; k < 4; k++) begin
      cyc();
      wake_req = 1'b0;
      if (!dram_cke || !cmd_ok) bad++;
    end
    chk("R12", "stray wake leaves pins", bad, 0);
    ref_seen = 1'b1;
    cyc();
    ref_seen  = 1'b0;
    enter_req = 1'b1;
    do_entry(0);
    sleep_and_wake(25, low);
    chk("R12", "residency not cut short", int'(low >= 26), 1);
    check_exit("after stray wake");
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_refresh_gate();
    t_same_cycle();
    t_bank_busy();
    t_odt_and_stray_wake();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule